// File: doc/BRIEF.md
# Off-Hook Timing Sequencer

This block controls the timing of a telephone line interface as it goes off-hook. A request comes either from a hardware pin or from a control bit. Once it arrives, the sequencer passes through a set of timed phases in a fixed order, and transmit and receive stay blocked until every enabled phase has finished.

The phases are, in order:

1. A fixed wait that covers the delay in sending the command to the line side.
2. A settling interval whose length is chosen by a two-bit field.
3. An optional resistor-calibration window.
4. An optional converter-calibration window.
5. An optional final wait that covers the delay of the downstream filter.

Every interval counts pulses on a `tick` input, so the block has no fixed link to the system clock rate. The calibration work itself is done elsewhere. This block only raises a strobe for the whole time each calibration is allowed to run.

The settle field and both skip bits are captured once, in the cycle the sequence starts. Later changes to them do not affect a sequence that is already running. The captured settle value comes out of reset as the 128 ms choice. If the request is removed in any phase, the block returns to idle on the next clock edge.

Top module: `offhook_seq`

## Requirements
- R1: While `phase` is idle (0) and `hook_pin` or `hook_bit` is high at a clock edge, `phase` becomes 1 (latency) at that edge and `busy` goes high.
- R2: With `tick` high every cycle, the latency phase lasts LAT_TICKS cycles and is followed by `phase` 2 (settle).
- R3: The settle phase lasts a number of ticks chosen by `settle_sel`: 00 gives SETTLE_LONG_TICKS (512 ms), 01 gives SETTLE_DEFAULT_TICKS (128 ms), 10 gives SETTLE_SHORT_TICKS (64 ms) and 11 gives SETTLE_MIN_TICKS (8 ms).
- R4: When `rcal_disable` is 0, `phase` 3 follows settle for RCAL_TICKS ticks with `rcal_active` high throughout. When it is 1, the phase is skipped and `rcal_active` never rises.
- R5: When `acal_disable` is 0, `phase` 4 follows for ACAL_TICKS ticks with `acal_active` high throughout. When it is 1, the phase is skipped and `acal_active` never rises.
- R6: With FILTER_WAIT=1, `phase` 5 lasts FILTER_TICKS ticks before ready. With FILTER_WAIT=0 there is no such phase.
- R7: `ready` is high only in `phase` 6. It stays high while the request is held, and `busy` is low there.
- R8: If both request inputs are low at an edge while `phase` is not idle, `phase` returns to 0 and `ready` to 0 at that edge. This holds even when a phase would have expired at the same edge.
- R9: `settle_sel`, `rcal_disable` and `acal_disable` are sampled only at the edge that starts a sequence. Changing them later does not alter the sequence timing.
- R10: A cycle in which `tick` is low does not advance any timed phase.
- R11: After reset, `phase` is 0 and `busy`, `ready`, `rcal_active` and `acal_active` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base pulse that advances interval counts |
| hook_pin | input | 1 | Off-hook request from the pin |
| hook_bit | input | 1 | Off-hook request from the control bit |
| settle_sel | input | 2 | Settling-time choice, captured at start |
| rcal_disable | input | 1 | Skip resistor calibration, captured at start |
| acal_disable | input | 1 | Skip converter calibration, captured at start |
| phase | output | 3 | Current phase: 0 idle, 1 latency, 2 settle, 3 rcal, 4 acal, 5 filter, 6 ready |
| busy | output | 1 | High during any timed phase |
| rcal_active | output | 1 | Resistor-calibration window strobe |
| acal_active | output | 1 | Converter-calibration window strobe |
| ready | output | 1 | Transmit and receive permitted |

## Verification
Two events can fall in the same cycle: the request being removed, and the last tick of a phase that would move the sequencer on. The bench provokes this by holding `tick` high and dropping the request on the exact cycle in which the latency phase makes its final count. Under R8 the abort must win, so `phase` must read idle after that edge and never settle. The bench also sweeps every combination of settle choice and skip bits on two instances, one with the filter wait and one without. For each combination it compares the cycle on which `ready` rises, and the number of cycles each calibration strobe is high, against sums worked out in the bench.

// File: rtl/offhook_pkg.sv
package offhook_pkg;

   typedef enum logic [2:0] {
      PH_IDLE    = 3'd0,
      PH_LATENCY = 3'd1,
      PH_SETTLE  = 3'd2,
      PH_RCAL    = 3'd3,
      PH_ACAL    = 3'd4,
      PH_FILTER  = 3'd5,
      PH_READY   = 3'd6
   } ohs_phase_e;

   typedef struct packed {
      logic [1:0] settle_sel;
      logic       rcal_skip;
      logic       acal_skip;
   } ohs_cfg_t;

   localparam logic [1:0] SETTLE_SEL_RESET = 2'b01;

   function automatic int unsigned ohs_max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ohs_cfg_capture.sv
module ohs_cfg_capture
   import offhook_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     load,
   input  ohs_cfg_t cfg_in,
   output ohs_cfg_t cfg_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q.settle_sel <= SETTLE_SEL_RESET;
         cfg_q.rcal_skip  <= 1'b0;
         cfg_q.acal_skip  <= 1'b0;
      end else if (load) begin
         cfg_q <= cfg_in;
      end
   end

endmodule

// File: rtl/ohs_interval.sv
module ohs_interval #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   output logic             done
);

   logic [CNT_W-1:0] cnt;

   assign done = tick && (cnt == (limit - CNT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= done ? '0 : cnt + CNT_W'(1);
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (limit != '0) |-> (cnt < limit)); // R2

endmodule

// File: rtl/ohs_phase_ctrl.sv
module ohs_phase_ctrl
   import offhook_pkg::*;
#(
   parameter bit FILTER_WAIT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req,
   input  logic       step_done,
   input  logic       rcal_skip,
   input  logic       acal_skip,
   output ohs_phase_e phase
);

   ohs_phase_e post_cal;
   ohs_phase_e after_rcal;
   ohs_phase_e after_settle;
   ohs_phase_e phase_nx;

   generate
      if (FILTER_WAIT) begin : g_filter
         assign post_cal = PH_FILTER;
      end else begin : g_nofilter
         assign post_cal = PH_READY;
      end
   endgenerate

   assign after_rcal   = acal_skip ? post_cal : PH_ACAL;
   assign after_settle = rcal_skip ? after_rcal : PH_RCAL;

   always_comb begin
      phase_nx = phase;
      if (phase != PH_IDLE && !req) begin
         phase_nx = PH_IDLE;
      end else begin
         unique case (phase)
            PH_IDLE:    if (req)       phase_nx = PH_LATENCY;
            PH_LATENCY: if (step_done) phase_nx = PH_SETTLE;
            PH_SETTLE:  if (step_done) phase_nx = after_settle;
            PH_RCAL:    if (step_done) phase_nx = after_rcal;
            PH_ACAL:    if (step_done) phase_nx = post_cal;
            PH_FILTER:  if (step_done) phase_nx = PH_READY;
            PH_READY:   phase_nx = PH_READY;
            default:    phase_nx = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_IDLE;
      else        phase <= phase_nx;
   end

   AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE && !req) |=> (phase == PH_IDLE)); // R8

   AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LATENCY && !$stable(phase)) |-> ($past(phase) == PH_IDLE)); // R1

   AST_NO_FILTER_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      (!FILTER_WAIT) |-> (phase != PH_FILTER)); // R6

endmodule

// File: rtl/offhook_seq.sv
module offhook_seq
   import offhook_pkg::*;
#(
   parameter int unsigned LAT_TICKS            = 5,
   parameter int unsigned SETTLE_LONG_TICKS    = 10240,
   parameter int unsigned SETTLE_DEFAULT_TICKS = 2560,
   parameter int unsigned SETTLE_SHORT_TICKS   = 1280,
   parameter int unsigned SETTLE_MIN_TICKS     = 160,
   parameter int unsigned RCAL_TICKS           = 340,
   parameter int unsigned ACAL_TICKS           = 5120,
   parameter bit          FILTER_WAIT          = 1'b1,
   parameter int unsigned FILTER_TICKS         = 30
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       hook_pin,
   input  logic       hook_bit,
   input  logic [1:0] settle_sel,
   input  logic       rcal_disable,
   input  logic       acal_disable,
   output logic [2:0] phase,
   output logic       busy,
   output logic       rcal_active,
   output logic       acal_active,
   output logic       ready
);

   localparam int unsigned MAX_SETTLE = ohs_max2(ohs_max2(SETTLE_LONG_TICKS, SETTLE_DEFAULT_TICKS),
                                                 ohs_max2(SETTLE_SHORT_TICKS, SETTLE_MIN_TICKS));
   localparam int unsigned MAX_CAL    = ohs_max2(RCAL_TICKS, ACAL_TICKS);
   localparam int unsigned MAX_MISC   = ohs_max2(LAT_TICKS, FILTER_TICKS);
   localparam int unsigned MAX_TICKS  = ohs_max2(ohs_max2(MAX_SETTLE, MAX_CAL), MAX_MISC);
   localparam int          CNT_W      = $clog2(MAX_TICKS + 1);

   initial begin
      assert (LAT_TICKS > 0) else $error("LAT_TICKS must be nonzero");
      assert (SETTLE_LONG_TICKS > 0 && SETTLE_DEFAULT_TICKS > 0 &&
              SETTLE_SHORT_TICKS > 0 && SETTLE_MIN_TICKS > 0)
         else $error("settle lengths must be nonzero");
      assert (RCAL_TICKS > 0 && ACAL_TICKS > 0) else $error("calibration lengths must be nonzero");
      assert (FILTER_TICKS > 0) else $error("FILTER_TICKS must be nonzero");
   end

   logic             req;
   ohs_phase_e       cur;
   ohs_cfg_t         cfg_in;
   ohs_cfg_t         cfg_q;
   logic             cfg_load;
   logic [CNT_W-1:0] settle_limit;
   logic [CNT_W-1:0] limit;
   logic             restart;
   logic             step_done;

   assign req      = hook_pin | hook_bit;
   assign cfg_load = (cur == PH_IDLE) && req;

   assign cfg_in.settle_sel = settle_sel;
   assign cfg_in.rcal_skip  = rcal_disable;
   assign cfg_in.acal_skip  = acal_disable;

   ohs_cfg_capture u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (cfg_load),
      .cfg_in (cfg_in),
      .cfg_q  (cfg_q)
   );

   always_comb begin
      unique case (cfg_q.settle_sel)
         2'b00:   settle_limit = CNT_W'(SETTLE_LONG_TICKS);
         2'b01:   settle_limit = CNT_W'(SETTLE_DEFAULT_TICKS);
         2'b10:   settle_limit = CNT_W'(SETTLE_SHORT_TICKS);
         default: settle_limit = CNT_W'(SETTLE_MIN_TICKS);
      endcase
   end

   always_comb begin
      unique case (cur)
         PH_LATENCY: limit = CNT_W'(LAT_TICKS);
         PH_SETTLE:  limit = settle_limit;
         PH_RCAL:    limit = CNT_W'(RCAL_TICKS);
         PH_ACAL:    limit = CNT_W'(ACAL_TICKS);
         PH_FILTER:  limit = CNT_W'(FILTER_TICKS);
         default:    limit = CNT_W'(1);
      endcase
   end

   assign restart = (cur == PH_IDLE) || (cur == PH_READY) || !req;

   ohs_interval #(.CNT_W(CNT_W)) u_interval (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .tick    (tick),
      .limit   (limit),
      .done    (step_done)
   );

   ohs_phase_ctrl #(.FILTER_WAIT(FILTER_WAIT)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .step_done (step_done),
      .rcal_skip (cfg_q.rcal_skip),
      .acal_skip (cfg_q.acal_skip),
      .phase     (cur)
   );

   assign phase       = cur;
   assign busy        = (cur != PH_IDLE) && (cur != PH_READY);
   assign rcal_active = (cur == PH_RCAL);
   assign acal_active = (cur == PH_ACAL);
   assign ready       = (cur == PH_READY);

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cfg_q)); // R9

   AST_TICK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && busy && req) |=> $stable(cur)); // R10

   AST_RCAL_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == PH_SETTLE && step_done && cfg_q.rcal_skip && req) |=> !rcal_active); // R4

   AST_ACAL_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (rcal_active && step_done && cfg_q.acal_skip && req) |=> !acal_active); // R5

   AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !ready); // R7

endmodule

// File: tb/offhook_seq_test.sv
module offhook_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam int LAT = 2;
   localparam int S00 = 9, S01 = 6, S10 = 4, S11 = 3;
   localparam int RC  = 4;
   localparam int AC  = 5;
   localparam int FT  = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b1;
   logic       hook_pin = 1'b0;
   logic       hook_bit = 1'b0;
   logic [1:0] settle_sel = 2'b00;
   logic       rcal_disable = 1'b0;
   logic       acal_disable = 1'b0;

   logic [2:0] phase, phase_nf;
   logic       busy, busy_nf, rca, rca_nf, aca, aca_nf, ready, ready_nf;

   int n_run  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   offhook_seq #(.LAT_TICKS(LAT), .SETTLE_LONG_TICKS(S00), .SETTLE_DEFAULT_TICKS(S01),
                 .SETTLE_SHORT_TICKS(S10), .SETTLE_MIN_TICKS(S11), .RCAL_TICKS(RC),
                 .ACAL_TICKS(AC), .FILTER_WAIT(1'b1), .FILTER_TICKS(FT)) uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .hook_pin(hook_pin), .hook_bit(hook_bit),
      .settle_sel(settle_sel), .rcal_disable(rcal_disable), .acal_disable(acal_disable),
      .phase(phase), .busy(busy), .rcal_active(rca), .acal_active(aca), .ready(ready));

   offhook_seq #(.LAT_TICKS(LAT), .SETTLE_LONG_TICKS(S00), .SETTLE_DEFAULT_TICKS(S01),
                 .SETTLE_SHORT_TICKS(S10), .SETTLE_MIN_TICKS(S11), .RCAL_TICKS(RC),
                 .ACAL_TICKS(AC), .FILTER_WAIT(1'b0), .FILTER_TICKS(FT)) uut_nf (
      .clk(clk), .rst_n(rst_n), .tick(tick), .hook_pin(hook_pin), .hook_bit(hook_bit),
      .settle_sel(settle_sel), .rcal_disable(rcal_disable), .acal_disable(acal_disable),
      .phase(phase_nf), .busy(busy_nf), .rcal_active(rca_nf), .acal_active(aca_nf),
      .ready(ready_nf));

   task automatic check(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic int settle_len(input logic [1:0] s);
      case (s)
         2'b00:   return S00;
         2'b01:   return S01;
         2'b10:   return S10;
         default: return S11;
      endcase
   endfunction

   task automatic drop_req();
      hook_pin = 1'b0;
      hook_bit = 1'b0;
      step();
      check("R8 idle after drop", int'(phase), 0);
      check("R8 ready low after drop", int'(ready), 0);
      step();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=complete");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      int exp_rdy, exp_nf, fr, fr_nf, rc_cnt, ac_cnt;
      repeat (3) @(negedge clk);
      check("R11 reset phase", int'(phase), 0);
      check("R11 reset busy", int'(busy), 0);
      check("R11 reset strobes", int'(rca) + int'(aca) + int'(ready), 0);
      rst_n = 1'b1;
      step();
      check("R11 idle without request", int'(phase), 0);

      // sweep of settle choice and skip bits
      for (int s = 0; s < 4; s++) begin
         for (int rd = 0; rd < 2; rd++) begin
            for (int ad = 0; ad < 2; ad++) begin
               settle_sel   = 2'(s);
               rcal_disable = rd[0];
               acal_disable = ad[0];
               if (s[0]) hook_bit = 1'b1; else hook_pin = 1'b1;
               exp_nf  = 1 + LAT + settle_len(2'(s)) + (rd ? 0 : RC) + (ad ? 0 : AC);
               exp_rdy = exp_nf + FT;
               fr = 0; fr_nf = 0; rc_cnt = 0; ac_cnt = 0;
               for (int k = 1; k <= 40; k++) begin
                  step();
                  if (k == 1) begin
                     check("R1 latency entered", int'(phase), 1);
                     check("R1 busy on start", int'(busy), 1);
                  end
                  if (k == 1 + LAT) check("R2 settle after latency", int'(phase), 2);
                  if (ready && fr == 0) fr = k;
                  if (ready_nf && fr_nf == 0) fr_nf = k;
                  if (rca) rc_cnt++;
                  if (aca) ac_cnt++;
                  if (ready && busy) check("R7 busy low when ready", 1, 0);
               end
               check("R3 R6 ready edge with filter", fr, exp_rdy);
               check("R3 R6 ready edge without filter", fr_nf, exp_nf);
               check("R4 rcal strobe cycles", rc_cnt, rd ? 0 : RC);
               check("R5 acal strobe cycles", ac_cnt, ad ? 0 : AC);
               check("R7 ready held", int'(ready), 1);
               check("R6 filter phase absent", int'(phase_nf), 6);
               drop_req();
            end
         end
      end

      // abort in every phase
      for (int p = 1; p <= 6; p++) begin
         settle_sel = 2'b11; rcal_disable = 1'b0; acal_disable = 1'b0;
         hook_pin = 1'b1;
         for (int k = 0; k < 40; k++) begin
            step();
            if (int'(phase) == p) break;
         end
         check("R8 reached phase", int'(phase), p);
         drop_req();
      end

      // abort on the same edge as latency expiry
      settle_sel = 2'b11; rcal_disable = 1'b1; acal_disable = 1'b1;
      hook_pin = 1'b1;
      step();
      step();
      hook_pin = 1'b0;
      step();
      check("R8 abort wins over expiry", int'(phase), 0);
      step();
      check("R8 stays idle", int'(phase), 0);

      // configuration changed mid-sequence
      settle_sel = 2'b11; rcal_disable = 1'b0; acal_disable = 1'b0;
      hook_bit = 1'b1;
      fr = 0;
      for (int k = 1; k <= 40; k++) begin
         step();
         if (k == 3) begin
            settle_sel = 2'b00; rcal_disable = 1'b1; acal_disable = 1'b1;
         end
         if (ready && fr == 0) fr = k;
      end
      check("R9 config frozen", fr, 1 + LAT + S11 + RC + AC + FT);
      drop_req();

      // tick held low during settle
      settle_sel = 2'b11; rcal_disable = 1'b1; acal_disable = 1'b1;
      hook_pin = 1'b1;
      fr = 0;
      for (int k = 1; k <= 40; k++) begin
         step();
         if (k == 3) tick = 1'b0;
         if (k == 13) begin
            check("R10 phase held without tick", int'(phase), 2);
            tick = 1'b1;
         end
         if (ready && fr == 0) fr = k;
      end
      check("R10 ready delayed by missing ticks", fr, 1 + LAT + S11 + FT + 10);
      drop_req();

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule